// File: doc/BRIEF.md
# Flash Page Programmer

This block sits on the host side of a byte-wide parallel flash device and writes one full page into it. A single start request carries a page number, a choice of protected or open write mode, and a choice of completion-detection method. The block fetches the page bytes from a local source in index order and drives the chip-enable, output-enable, write-enable, address and data pins. Each write has a setup phase, a low strobe and a recovery phase, and every length is a parameter in system-clock cycles.

In protected mode three fixed unlock writes go ahead of the page data. Once the last byte is written, the block reads the last written address over and over. It decides the device has finished either when bit 7 matches the true value of the last byte, or when bit 6 reads the same on two reads in a row. It finishes with a one-cycle done pulse, or with a one-cycle timeout pulse if the poll window runs out first.

Top module: `flash_page_writer`

## Requirements
- R1: While reset is held and straight after it, chip enable, output enable and write enable are all high (inactive), the data drive enable is low, and busy, byteReq, done and timeoutErr are low.
- R2: A start sampled high while busy is low launches a command, and busy is high from the next cycle on. A start seen while busy is high has no effect on any pin.
- R3: Each write drives its address and data with write enable high for SETUP_CYC cycles, then write enable low for PULSE_CYC cycles, then high for HOLD_CYC cycles. Address and data stay constant across all three phases. Chip enable stays low for the whole command, and output enable is high whenever chip enable and write enable are both low.
- R4: When protectMode was high at start, the first three writes are data 0xAA to address 0x5555, data 0x55 to address 0x2AAA, and data 0xA0 to address 0x5555, in that order.
- R5: Exactly 64 page writes follow, for byte indices 0 to 63 in order. The address is {pageNum, index}, with the page in bits 14..6 and the index in bits 5..0. The data is byteData as sampled in the single cycle in which byteReq is high and byteIdx shows that index, which is the cycle just before the write's setup phase.
- R6: From the rise of write enable to the next fall within a command there are HOLD_CYC+1+SETUP_CYC cycles, and this must stay below the device's inter-byte limit.
- R7: After the last write, the block reads the last written address with output enable low for READ_CYC cycles and then high for OE_HIGH_CYC cycles, and repeats this. Input data is sampled in the last low cycle.
- R8: With pollToggle low at start, a read whose bit 7 equals bit 7 of the last page byte ends the command with done.
- R9: With pollToggle high at start, a read whose bit 6 equals bit 6 of the previous read in the same command ends the command with done. The first read can never end it.
- R10: If no completing read has been sampled by poll cycle POLL_LIMIT-1 (counted from the first read cycle), the command ends with timeoutErr. A completion in that same cycle takes priority.
- R11: done and timeoutErr are single-cycle pulses in the first cycle with busy low, never high together, and busy only falls together with one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command request |
| pageNum | input | PAGE_W | Page to program |
| protectMode | input | 1 | Prefix the unlock writes |
| pollToggle | input | 1 | 1: bit-6 toggle polling, 0: bit-7 polling |
| byteReq | output | 1 | Byte fetch strobe |
| byteIdx | output | OFS_W | Index of the byte fetched |
| byteData | input | DATA_W | Fetched byte, valid in the byteReq cycle |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| timeoutErr | output | 1 | Poll timeout pulse |
| flashCeN | output | 1 | Chip enable, active low |
| flashOeN | output | 1 | Output enable, active low |
| flashWeN | output | 1 | Write enable, active low |
| flashAddr | output | ADDR_W | Flash address |
| flashDout | output | DATA_W | Write data toward the flash |
| flashDoutEn | output | 1 | Data bus drive enable |
| flashDin | input | DATA_W | Read data from the flash |

## Verification
The hardest conditions to reach are the completion decisions. Toggle polling must see bit 6 alternate through busy reads and then repeat, and a timeout must beat a completion that comes too late. The bench contains a small flash model. It counts finished reads and returns the complemented bit 7 with an alternating bit 6 for a chosen number of reads, then returns the true last byte. That count is set per command: zero, a few, and far past the poll limit. Starts are also injected in the middle of a command to show they are ignored.

// File: rtl/fpw_pkg.sv
package fpw_pkg;

  localparam int UNLOCK_LEN = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PREP, ST_SETUP, ST_PULSE, ST_HIGH, ST_RDLOW, ST_RDHIGH
  } fpwState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       accept;     // command accepted, latch page and poll mode
    logic       ldItem;     // load address/data of the next write
    logic       useUnlock;  // the next write is an unlock word
    logic [1:0] unlockSel;  // which unlock word
    logic       clrPoll;    // entering the poll phase
    logic       pollStep;   // one poll cycle elapsed
    logic       capture;    // sample read data this cycle
  } fpwStrobe_t;

  function automatic logic [14:0] unlockAddr(input logic [1:0] sel);
    return (sel == 2'd1) ? 15'h2AAA : 15'h5555;
  endfunction

  function automatic logic [7:0] unlockData(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8'hAA;
      2'd1:    return 8'h55;
      default: return 8'hA0;
    endcase
  endfunction

endpackage

// File: rtl/fpw_ctrl.sv
module fpw_ctrl
  import fpw_pkg::*;
#(
  parameter int PAGE_BYTES  = 64,
  parameter int SETUP_CYC   = 10,
  parameter int PULSE_CYC   = 25,
  parameter int HOLD_CYC    = 26,
  parameter int READ_CYC    = 25,
  parameter int OE_HIGH_CYC = 40,
  localparam int OFS_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             protectMode,
  input  logic             pollHit,
  input  logic             timeoutHit,
  output fpwStrobe_t       strb,
  output logic [OFS_W-1:0] byteIdx,
  output logic             byteReq,
  output logic             busy,
  output logic             done,
  output logic             timeoutErr,
  output logic             flashCeN,
  output logic             flashOeN,
  output logic             flashWeN,
  output logic             flashDoutEn
);

  localparam int M1     = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int M2     = (HOLD_CYC > READ_CYC) ? HOLD_CYC : READ_CYC;
  localparam int M3     = (M1 > M2) ? M1 : M2;
  localparam int PH_MAX = (M3 > OE_HIGH_CYC) ? M3 : OE_HIGH_CYC;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int ITEM_W = $clog2(PAGE_BYTES + UNLOCK_LEN + 1);

  fpwState_e         state, stateNext;
  logic [PH_W-1:0]   phCnt, phLen;
  logic [ITEM_W-1:0] itemCnt, prefix, byteOfs;
  logic              protQ, phEnd, isUnlock, lastItem, doneSet, errSet;

  assign prefix   = protQ ? ITEM_W'(UNLOCK_LEN) : '0;
  assign isUnlock = protQ && (itemCnt < ITEM_W'(UNLOCK_LEN));
  assign lastItem = (itemCnt == ITEM_W'(PAGE_BYTES - 1) + prefix);
  assign byteOfs  = itemCnt - prefix;
  assign byteIdx  = byteOfs[OFS_W-1:0];

  always_comb begin
    case (state)
      ST_SETUP:  phLen = PH_W'(SETUP_CYC - 1);
      ST_PULSE:  phLen = PH_W'(PULSE_CYC - 1);
      ST_HIGH:   phLen = PH_W'(HOLD_CYC - 1);
      ST_RDLOW:  phLen = PH_W'(READ_CYC - 1);
      ST_RDHIGH: phLen = PH_W'(OE_HIGH_CYC - 1);
      default:   phLen = '0;
    endcase
  end
  assign phEnd = (phCnt == phLen);

  always_comb begin
    stateNext = state;
    doneSet   = 1'b0;
    errSet    = 1'b0;
    case (state)
      ST_IDLE:  if (start) stateNext = ST_PREP;
      ST_PREP:  stateNext = ST_SETUP;
      ST_SETUP: if (phEnd) stateNext = ST_PULSE;
      ST_PULSE: if (phEnd) stateNext = ST_HIGH;
      ST_HIGH:  if (phEnd) stateNext = lastItem ? ST_RDLOW : ST_PREP;
      ST_RDLOW: begin
        if (phEnd && pollHit) begin
          stateNext = ST_IDLE;
          doneSet   = 1'b1;
        end else if (timeoutHit) begin
          stateNext = ST_IDLE;
          errSet    = 1'b1;
        end else if (phEnd) begin
          stateNext = ST_RDHIGH;
        end
      end
      ST_RDHIGH: begin
        if (timeoutHit) begin
          stateNext = ST_IDLE;
          errSet    = 1'b1;
        end else if (phEnd) begin
          stateNext = ST_RDLOW;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      phCnt      <= '0;
      itemCnt    <= '0;
      protQ      <= 1'b0;
      done       <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      state      <= stateNext;
      phCnt      <= (stateNext != state) ? '0 : phCnt + 1'b1;
      done       <= doneSet;
      timeoutErr <= errSet;
      if (state == ST_IDLE && start) begin
        itemCnt <= '0;
        protQ   <= protectMode;
      end else if (state == ST_HIGH && phEnd) begin
        itemCnt <= itemCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb           = '0;
    strb.accept    = (state == ST_IDLE) && start;
    strb.ldItem    = (state == ST_PREP);
    strb.useUnlock = isUnlock;
    strb.unlockSel = itemCnt[1:0];
    strb.clrPoll   = (state == ST_HIGH) && phEnd && lastItem;
    strb.pollStep  = (state == ST_RDLOW) || (state == ST_RDHIGH);
    strb.capture   = (state == ST_RDLOW) && phEnd;
  end

  assign busy        = (state != ST_IDLE);
  assign byteReq     = (state == ST_PREP) && !isUnlock;
  assign flashCeN    = (state == ST_IDLE);
  assign flashOeN    = (state != ST_RDLOW);
  assign flashWeN    = (state != ST_PULSE);
  assign flashDoutEn = (state == ST_SETUP) || (state == ST_PULSE) || (state == ST_HIGH);

endmodule

// File: rtl/fpw_datapath.sv
module fpw_datapath
  import fpw_pkg::*;
#(
  parameter int PAGE_W     = 9,
  parameter int OFS_W      = 6,
  parameter int DATA_W     = 8,
  parameter int POLL_LIMIT = 2750000,
  localparam int ADDR_W = PAGE_W + OFS_W,
  localparam int TM_W   = $clog2(POLL_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fpwStrobe_t        strb,
  input  logic [PAGE_W-1:0] pageNum,
  input  logic              pollToggle,
  input  logic [OFS_W-1:0]  byteIdx,
  input  logic [DATA_W-1:0] byteData,
  input  logic [DATA_W-1:0] flashDin,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [DATA_W-1:0] flashDout,
  output logic              pollHit,
  output logic              timeoutHit
);

  logic [PAGE_W-1:0] pageQ;
  logic              toggleQ, prevBit6, prevValid;
  logic [TM_W-1:0]   timer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageQ     <= '0;
      toggleQ   <= 1'b0;
      flashAddr <= '0;
      flashDout <= '0;
      timer     <= '0;
      prevBit6  <= 1'b0;
      prevValid <= 1'b0;
    end else begin
      if (strb.accept) begin
        pageQ   <= pageNum;
        toggleQ <= pollToggle;
      end
      if (strb.ldItem) begin
        if (strb.useUnlock) begin
          flashAddr <= ADDR_W'(unlockAddr(strb.unlockSel));
          flashDout <= DATA_W'(unlockData(strb.unlockSel));
        end else begin
          flashAddr <= {pageQ, byteIdx};
          flashDout <= byteData;
        end
      end
      if (strb.clrPoll) begin
        timer     <= '0;
        prevValid <= 1'b0;
      end else begin
        if (strb.pollStep) timer <= timer + 1'b1;
        if (strb.capture) begin
          prevBit6  <= flashDin[DATA_W-2];
          prevValid <= 1'b1;
        end
      end
    end
  end

  // flashDout still holds the last page byte while polling
  assign pollHit    = toggleQ ? (prevValid && (flashDin[DATA_W-2] == prevBit6))
                              : (flashDin[DATA_W-1] == flashDout[DATA_W-1]);
  assign timeoutHit = (timer == TM_W'(POLL_LIMIT - 1));

endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer
  import fpw_pkg::*;
#(
  parameter int PAGE_W      = 9,
  parameter int PAGE_BYTES  = 64,
  parameter int DATA_W      = 8,
  parameter int SETUP_CYC   = 10,
  parameter int PULSE_CYC   = 25,
  parameter int HOLD_CYC    = 26,
  parameter int READ_CYC    = 25,
  parameter int OE_HIGH_CYC = 40,
  parameter int POLL_LIMIT  = 2750000,
  localparam int OFS_W  = $clog2(PAGE_BYTES),
  localparam int ADDR_W = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [PAGE_W-1:0] pageNum,
  input  logic              protectMode,
  input  logic              pollToggle,
  output logic              byteReq,
  output logic [OFS_W-1:0]  byteIdx,
  input  logic [DATA_W-1:0] byteData,
  output logic              busy,
  output logic              done,
  output logic              timeoutErr,
  output logic              flashCeN,
  output logic              flashOeN,
  output logic              flashWeN,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [DATA_W-1:0] flashDout,
  output logic              flashDoutEn,
  input  logic [DATA_W-1:0] flashDin
);

  fpwStrobe_t strb;
  logic       pollHit, timeoutHit;

  fpw_ctrl #(
    .PAGE_BYTES(PAGE_BYTES), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC(HOLD_CYC), .READ_CYC(READ_CYC), .OE_HIGH_CYC(OE_HIGH_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .protectMode(protectMode),
    .pollHit(pollHit), .timeoutHit(timeoutHit), .strb(strb),
    .byteIdx(byteIdx), .byteReq(byteReq), .busy(busy), .done(done),
    .timeoutErr(timeoutErr), .flashCeN(flashCeN), .flashOeN(flashOeN),
    .flashWeN(flashWeN), .flashDoutEn(flashDoutEn)
  );

  fpw_datapath #(
    .PAGE_W(PAGE_W), .OFS_W(OFS_W), .DATA_W(DATA_W), .POLL_LIMIT(POLL_LIMIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pageNum(pageNum),
    .pollToggle(pollToggle), .byteIdx(byteIdx), .byteData(byteData),
    .flashDin(flashDin), .flashAddr(flashAddr), .flashDout(flashDout),
    .pollHit(pollHit), .timeoutHit(timeoutHit)
  );

endmodule

// File: rtl/fpw_checker.sv
module fpw_checker #(
  parameter int PAGE_W      = 9,
  parameter int PAGE_BYTES  = 64,
  parameter int DATA_W      = 8,
  parameter int PULSE_CYC   = 25,
  parameter int MAX_GAP_CYC = 37500,
  localparam int OFS_W  = $clog2(PAGE_BYTES),
  localparam int ADDR_W = PAGE_W + OFS_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [PAGE_W-1:0] pageNum,
  input logic              protectMode,
  input logic              busy,
  input logic              done,
  input logic              timeoutErr,
  input logic              flashCeN,
  input logic              flashOeN,
  input logic              flashWeN,
  input logic [ADDR_W-1:0] flashAddr,
  input logic [DATA_W-1:0] flashDout
);

  int                lowCnt, highCnt, strobeCnt;
  logic              prevWe, seenRise, protLatched;
  logic [PAGE_W-1:0] pageLatched;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt      <= 0;
      highCnt     <= 0;
      strobeCnt   <= 0;
      prevWe      <= 1'b1;
      seenRise    <= 1'b0;
      protLatched <= 1'b0;
      pageLatched <= '0;
    end else begin
      prevWe  <= flashWeN;
      lowCnt  <= flashWeN ? 0 : lowCnt + 1;
      highCnt <= flashWeN ? highCnt + 1 : 0;
      if (start && !busy) begin
        protLatched <= protectMode;
        pageLatched <= pageNum;
        strobeCnt   <= 0;
        seenRise    <= 1'b0;
      end else begin
        if (prevWe && !flashWeN) strobeCnt <= strobeCnt + 1;
        if (!prevWe && flashWeN) seenRise <= 1'b1;
      end
    end
  end

  AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!flashCeN && !flashWeN) |-> flashOeN); // R3
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashWeN) |-> (lowCnt == PULSE_CYC)); // R3
  AST_PINS_STABLE_IN_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (!flashWeN && $past(!flashWeN)) |-> ($stable(flashAddr) && $stable(flashDout))); // R3
  AST_UNLOCK_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(flashWeN) && protLatched && strobeCnt == 0) |->
      (flashAddr == ADDR_W'(15'h5555) && flashDout == DATA_W'(8'hAA))); // R4
  AST_PAGE_BITS: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(flashWeN) && strobeCnt >= (protLatched ? 3 : 0)) |->
      (flashAddr[ADDR_W-1:OFS_W] == pageLatched)); // R5
  AST_STROBE_TOTAL: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (strobeCnt == PAGE_BYTES + (protLatched ? 3 : 0))); // R5
  AST_GAP_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(flashWeN) && seenRise) |-> (highCnt < MAX_GAP_CYC)); // R6
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(done && timeoutErr)); // R11
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done || timeoutErr)); // R11

endmodule

bind flash_page_writer fpw_checker #(
  .PAGE_W(PAGE_W), .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W), .PULSE_CYC(PULSE_CYC)
) u_fpw_checker (
  .clk(clk), .rstN(rstN), .start(start), .pageNum(pageNum),
  .protectMode(protectMode), .busy(busy), .done(done), .timeoutErr(timeoutErr),
  .flashCeN(flashCeN), .flashOeN(flashOeN), .flashWeN(flashWeN),
  .flashAddr(flashAddr), .flashDout(flashDout)
);

// File: tb/flash_page_writer_bench.sv
`timescale 1ns/1ps
module flash_page_writer_bench;

  localparam int S = 2, P = 3, H = 2, RD = 2, G = 2, L = 40;
  localparam int MAX_GAP = 37500;

  logic       clk = 1'b0, rstN = 1'b0, start = 1'b0, protectMode = 1'b0, pollToggle = 1'b0;
  logic [8:0] pageNum = '0;
  logic       byteReq, busy, done, timeoutErr, flashCeN, flashOeN, flashWeN, flashDoutEn;
  logic [5:0] byteIdx;
  logic [7:0] byteData, flashDout, flashDin;
  logic [14:0] flashAddr;

  always #2 clk = ~clk;

  flash_page_writer #(
    .SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H), .READ_CYC(RD),
    .OE_HIGH_CYC(G), .POLL_LIMIT(L)
  ) u_flash_page_writer (
    .clk(clk), .rstN(rstN), .start(start), .pageNum(pageNum),
    .protectMode(protectMode), .pollToggle(pollToggle), .byteReq(byteReq),
    .byteIdx(byteIdx), .byteData(byteData), .busy(busy), .done(done),
    .timeoutErr(timeoutErr), .flashCeN(flashCeN), .flashOeN(flashOeN),
    .flashWeN(flashWeN), .flashAddr(flashAddr), .flashDout(flashDout),
    .flashDoutEn(flashDoutEn), .flashDin(flashDin)
  );

  typedef struct {
    bit ceN, oeN, weN, doutEn, byteReq, busy, done, err;
    logic [14:0] addr;
    logic [7:0]  dout;
    logic [5:0]  idx;
    string       tag;
  } rec_t;

  rec_t q[$];
  int   errors = 0, checks = 0, cycles = 0;
  logic [14:0] curAddr = '0;
  logic [7:0]  seed = '0, lastByte = '0;
  int   busyReads = 0, readNum = 0;
  int   doneCnt = 0, errCnt = 0;
  bit   prevOe = 1'b1, prevWe = 1'b1, seenRise = 1'b0, monOn = 1'b0;
  int   hiRun = 0;

  function automatic logic [7:0] srcByte(input logic [5:0] i, input logic [7:0] sd);
    return 8'({2'b00, i} * 8'd37) + sd;
  endfunction

  function automatic logic [7:0] flashVal(input int n, input int k, input logic [7:0] lb);
    if (n < k) return {~lb[7], n[0], 6'h15};
    return lb;
  endfunction

  assign byteData = srcByte(byteIdx, seed);
  assign flashDin = flashOeN ? 8'h00 : flashVal(readNum, busyReads, lastByte);

  function automatic rec_t idleRec();
    rec_t r;
    r.ceN = 1; r.oeN = 1; r.weN = 1; r.doutEn = 0; r.byteReq = 0; r.busy = 0;
    r.done = 0; r.err = 0; r.addr = curAddr; r.dout = 0; r.idx = 0; r.tag = "R2";
    return r;
  endfunction

  task automatic fail(input string tag, input string what, input int act, input int exp);
    errors++;
    $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cycles);
  endtask

  // one write: prep, setup, pulse, recovery
  task automatic pushWrite(input logic [14:0] a, input logic [7:0] d, input bit isPage,
                           input logic [5:0] i, input string tag);
    rec_t r;
    r = idleRec(); r.ceN = 0; r.busy = 1; r.byteReq = isPage; r.idx = i; r.tag = tag;
    q.push_back(r);
    curAddr = a;
    r.addr = a; r.dout = d; r.doutEn = 1; r.byteReq = 0;
    for (int k = 0; k < S; k++) q.push_back(r);
    r.weN = 0;
    for (int k = 0; k < P; k++) q.push_back(r);
    r.weN = 1;
    for (int k = 0; k < H; k++) q.push_back(r);
  endtask

  task automatic runCmd(input logic [8:0] pg, input bit prot, input bit tog, input int k,
                        input logic [7:0] sd, input bit inject, input string endTag);
    rec_t r;
    int endT, expDone, expErr, t;
    bit prev6, hit;
    logic [7:0] v;
    @(negedge clk);
    seed = sd; lastByte = srcByte(6'd63, sd); busyReads = k; readNum = 0;
    doneCnt = 0; errCnt = 0; seenRise = 0;
    pageNum = pg; protectMode = prot; pollToggle = tog; start = 1;
    @(posedge clk); #1 start = 0;
    if (prot) begin
      pushWrite(15'h5555, 8'hAA, 0, 0, "R4");
      pushWrite(15'h2AAA, 8'h55, 0, 0, "R4");
      pushWrite(15'h5555, 8'hA0, 0, 0, "R4");
    end
    for (int i = 0; i < 64; i++)
      pushWrite({pg, 6'(i)}, srcByte(6'(i), sd), 1, 6'(i), "R5");
    endT = L - 1; expDone = 0; prev6 = 0;
    for (int n = 0; n * (RD + G) + RD - 1 <= L - 1; n++) begin
      v = flashVal(n, k, lastByte);
      hit = tog ? (n > 0 && v[6] == prev6) : (v[7] == lastByte[7]);
      prev6 = v[6];
      if (hit) begin endT = n * (RD + G) + RD - 1; expDone = 1; break; end
    end
    expErr = !expDone;
    for (t = 0; t <= endT; t++) begin
      r = idleRec(); r.ceN = 0; r.busy = 1; r.tag = "R7";
      r.oeN = ((t % (RD + G)) >= RD);
      q.push_back(r);
    end
    r = idleRec(); r.done = expDone; r.err = expErr; r.tag = endTag;
    q.push_back(r);
    if (inject) begin
      repeat (20) @(negedge clk);
      pageNum = 9'h0F0; protectMode = ~prot; start = 1;
      repeat (3) @(negedge clk);
      start = 0;
    end
    while (q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    checks++;
    if (doneCnt != expDone) fail(endTag, "done pulse count", doneCnt, expDone);
    checks++;
    if (errCnt != expErr) fail("R11", "timeoutErr pulse count", errCnt, expErr);
  endtask

  // per-cycle comparison against the reference trace
  always @(negedge clk) begin
    rec_t e;
    string tt;
    cycles++;
    if (monOn) begin
      e = (q.size() > 0) ? q.pop_front() : idleRec();
      tt = (e.tag == "R7") ? "R7" : "R3";
      checks++;
      if (flashCeN !== e.ceN || flashOeN !== e.oeN || flashWeN !== e.weN || flashDoutEn !== e.doutEn)
        fail(tt, "ce/oe/we/den", {flashCeN, flashOeN, flashWeN, flashDoutEn},
             {e.ceN, e.oeN, e.weN, e.doutEn});
      else if (busy !== e.busy) fail("R2", "busy", busy, e.busy);
      else if (done !== e.done) fail(e.done ? e.tag : "R11", "done", done, e.done);
      else if (timeoutErr !== e.err) fail("R10", "timeoutErr", timeoutErr, e.err);
      else if (flashAddr !== e.addr) fail(e.tag, "address", flashAddr, e.addr);
      else if (e.doutEn && flashDout !== e.dout) fail(e.tag, "write data", flashDout, e.dout);
      else if (byteReq !== e.byteReq) fail("R5", "byteReq", byteReq, e.byteReq);
      else if (e.byteReq && byteIdx !== e.idx) fail("R5", "byteIdx", byteIdx, e.idx);
      if (done) doneCnt++;
      if (timeoutErr) errCnt++;
      // R6: strobe gap measured at the pins
      if (!flashWeN && prevWe && seenRise) begin
        checks++;
        if (hiRun != H + 1 + S || hiRun >= MAX_GAP) fail("R6", "strobe gap", hiRun, H + 1 + S);
      end
      if (flashWeN && !prevWe) seenRise = 1;
      hiRun = flashWeN ? hiRun + 1 : 0;
      prevWe = flashWeN;
      if (flashOeN && !prevOe) readNum++;
      prevOe = flashOeN;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R1 during reset
    if ({flashCeN, flashOeN, flashWeN, flashDoutEn, busy, byteReq, done, timeoutErr} !== 8'b11100000)
      fail("R1", "pins in reset", {flashCeN, flashOeN, flashWeN, flashDoutEn, busy, byteReq, done, timeoutErr}, 8'hE0);
    rstN = 1;
    @(negedge clk);
    checks++;  // R1 after release
    if ({flashCeN, flashOeN, flashWeN, flashDoutEn, busy, byteReq, done, timeoutErr} !== 8'b11100000)
      fail("R1", "pins after reset", {flashCeN, flashOeN, flashWeN, flashDoutEn, busy, byteReq, done, timeoutErr}, 8'hE0);
    monOn = 1;
    runCmd(9'h005, 0, 0, 3,   8'h11, 0, "R8");   // open write, bit-7 polling
    runCmd(9'h1FF, 1, 1, 4,   8'h40, 1, "R9");   // protected, toggle, starts injected while busy
    runCmd(9'h0A3, 0, 0, 100, 8'h07, 0, "R10");  // device never completes
    runCmd(9'h000, 1, 1, 0,   8'hC3, 0, "R9");   // toggle, finished at once: second read ends it
    runCmd(9'h155, 1, 0, 0,   8'h9A, 0, "R8");   // bit-7, first read ends it
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule